// File: doc/BRIEF.md
# CAN Receive Acceptance Filter

This block sits behind a CAN receiver and decides which entry of a small table of message objects, if any, accepts an incoming frame header. A header gives the identifier, whether the frame uses the 11-bit base format or the 29-bit extended format, and the data length code. Each of the up to fifteen objects holds an enable flag, a direction flag, a format flag and a stored identifier. All objects compare through one shared acceptance mask. The last object can be switched to a catch-all buffer role, in which it uses a mask of its own and takes only frames that no other object claimed.

Headers arrive on a valid/ready stream. Results leave on a second valid/ready stream: a hit flag, the object number and the payload length, clamped to eight bytes. A header is accepted in any cycle where `hdr_valid` and `hdr_ready` are both high. The result appears in the next cycle. While a result is held by a low `res_ready`, `hdr_ready` stays low and the result stays unchanged. Software fills the table, the two masks and the buffer-mode bit through a single-cycle write port. Each write changes exactly one register.

Configuration write map (`cfg_addr`): 0 to 14 select objects 1 to 15. 16 is the shared mask, 17 is the buffer mask and 18 is the mode register (bit 0 turns on buffer mode). An object word is laid out as: bit 31 enabled, bit 30 receive direction (1 = receive), bit 29 extended format, bits 28:0 identifier. A mask word uses bits 28:0. A base-format identifier is placed in bits 28:18.

Top module: `can_accept_filter`

## Requirements
- R1: For an extended frame (`hdr_ext`=1), every identifier bit 28:0 whose shared-mask bit is 1 must equal the stored bit for the object to match.
- R2: For a base frame (`hdr_ext`=0), only identifier and mask bits 28:18 take part in the compare; bits 17:0 of the header, the stored identifier and the mask have no effect.
- R3: An object matches only if its enable bit (31) is 1, its direction bit (30) is 1 (receive), and its format bit (29) equals `hdr_ext`.
- R4: A mask bit of 0 makes the corresponding identifier bit don't-care, so one object can accept a range of identifiers.
- R5: When several objects match, the result reports the lowest-numbered one. Objects are numbered 1 to 15 in `res_obj`.
- R6: With buffer mode on (mode bit 0 = 1), object 15 compares through the buffer mask, and it is reported only when none of objects 1 to 14 match.
- R7: With buffer mode off, object 15 compares through the shared mask like any other object.
- R8: `res_len` equals the header's length code when that code is 8 or less, and 8 otherwise.
- R9: A header accepted at one clock edge yields `res_valid`=1 after the next edge. A miss reports `res_hit`=0 and `res_obj`=0. A hit reports `res_hit`=1 and a nonzero `res_obj`.
- R10: While `res_valid`=1 and `res_ready`=0, `hdr_ready` is 0 and all result outputs hold their values. Otherwise `hdr_ready` is 1.
- R11: A write to one object address changes that object only; the matching of every other object is unaffected.
- R12: After reset, `res_valid` is 0, every object is disabled, both masks are all ones and buffer mode is off, so any header misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| hdr_valid | input | 1 | Header stream valid |
| hdr_ready | output | 1 | Header stream ready |
| hdr_id | input | 29 | Frame identifier (base format in bits 28:18) |
| hdr_ext | input | 1 | 1 = extended 29-bit frame |
| hdr_dlc | input | 4 | Data length code |
| res_valid | output | 1 | Result stream valid |
| res_ready | input | 1 | Result stream ready |
| res_hit | output | 1 | An object accepted the frame |
| res_obj | output | 4 | Accepting object number, 0 on miss |
| res_len | output | 4 | Payload length clamped to 8 |

## Verification
The checker assumes that the result consumer follows the stream rules. A result that is stalled by a low `res_ready` must therefore be judged for stability only against the design's own outputs. The checker also assumes that configuration writes never collide with a header in a way the bench must order. The bench keeps to this: it drives every input on the falling edge, makes configuration writes only while no header is in flight, and holds `hdr_valid` across a stall until the header is taken. Sweeps cover every base identifier under several mask and mode settings, every single-bit flip of a stored extended identifier, and all sixteen length codes.

// File: rtl/can_flt_pkg.sv
package can_flt_pkg;
  localparam int OBJ_N   = 15;
  localparam int ID_W    = 29;
  localparam int STD_W   = 11;
  localparam int DLC_W   = 4;
  localparam int MAX_LEN = 8;
  localparam int ADDR_W  = 5;
  localparam int OBJ_IW  = $clog2(OBJ_N + 1);

  // one table entry; its packed layout is the configuration word layout
  typedef struct packed {
    logic            en;
    logic            rx;
    logic            ext;
    logic [ID_W-1:0] id;
  } obj_t;

  localparam int DATA_W = $bits(obj_t);

  localparam logic [ADDR_W-1:0] A_FMASK = ADDR_W'(16);
  localparam logic [ADDR_W-1:0] A_BMASK = ADDR_W'(17);
  localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(18);
endpackage

// File: rtl/can_flt_regs.sv
module can_flt_regs
  import can_flt_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [ADDR_W-1:0]         cfg_addr,
  input  logic [DATA_W-1:0]         cfg_wdata,
  output obj_t [OBJ_N-1:0]          tbl,
  output logic [ID_W-1:0]           full_mask,
  output logic [ID_W-1:0]           buf_mask,
  output logic                      buf_mode
);
  logic unused_cfg_bits;
  assign unused_cfg_bits = ^cfg_wdata[DATA_W-1:ID_W];

  // each slot owns its own register so a write touches one entry only
  for (genvar s = 0; s < OBJ_N; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        tbl[s] <= '0;
      else if (cfg_we && cfg_addr == ADDR_W'(s))
        tbl[s] <= obj_t'(cfg_wdata);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_mask <= '1;
      buf_mask  <= '1;
      buf_mode  <= 1'b0;
    end else if (cfg_we) begin
      if (cfg_addr == A_FMASK) full_mask <= cfg_wdata[ID_W-1:0];
      if (cfg_addr == A_BMASK) buf_mask  <= cfg_wdata[ID_W-1:0];
      if (cfg_addr == A_MODE)  buf_mode  <= cfg_wdata[0];
    end
  end
endmodule

// File: rtl/can_flt_match.sv
module can_flt_match
  import can_flt_pkg::*;
(
  input  obj_t            entry,
  input  logic [ID_W-1:0] mask,
  input  logic [ID_W-1:0] frm_id,
  input  logic            frm_ext,
  output logic            hit
);
  logic [ID_W-1:0] eff_mask;
  logic [ID_W-1:0] diff;

  // base frames only look at the top STD_W bits
  assign eff_mask = frm_ext ? mask : {mask[ID_W-1 -: STD_W], {(ID_W-STD_W){1'b0}}};
  assign diff     = (frm_id ^ entry.id) & eff_mask;
  assign hit      = entry.en && entry.rx && (entry.ext == frm_ext) && (diff == '0);
endmodule

// File: rtl/can_flt_prio.sv
module can_flt_prio
  import can_flt_pkg::*;
(
  input  logic [OBJ_N-1:0]  req,
  output logic              any,
  output logic [OBJ_IW-1:0] num
);
  always_comb begin
    any = 1'b0;
    num = '0;
    for (int k = OBJ_N - 1; k >= 0; k--) begin
      if (req[k]) begin
        any = 1'b1;
        num = OBJ_IW'(k + 1);
      end
    end
  end
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
  import can_flt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [4:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              hdr_valid,
  output logic              hdr_ready,
  input  logic [28:0]       hdr_id,
  input  logic              hdr_ext,
  input  logic [3:0]        hdr_dlc,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_hit,
  output logic [3:0]        res_obj,
  output logic [3:0]        res_len
);
  localparam int LAST = OBJ_N - 1;

  obj_t [OBJ_N-1:0] tbl;
  logic [ID_W-1:0]  full_mask;
  logic [ID_W-1:0]  buf_mask;
  logic             buf_mode;

  can_flt_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .tbl       (tbl),
    .full_mask (full_mask),
    .buf_mask  (buf_mask),
    .buf_mode  (buf_mode)
  );

  logic [OBJ_N-1:0] raw_hit;

  for (genvar s = 0; s < OBJ_N; s++) begin : g_cmp
    logic [ID_W-1:0] sel_mask;
    if (s == LAST) begin : g_last
      assign sel_mask = buf_mode ? buf_mask : full_mask;
    end else begin : g_full
      assign sel_mask = full_mask;
    end
    can_flt_match u_m (
      .entry   (tbl[s]),
      .mask    (sel_mask),
      .frm_id  (hdr_id),
      .frm_ext (hdr_ext),
      .hit     (raw_hit[s])
    );
  end

  // in buffer mode the last slot is pulled out of the ranked set
  logic [OBJ_N-1:0]  ranked;
  logic              ranked_any;
  logic [OBJ_IW-1:0] ranked_num;
  logic              buf_take;

  assign ranked   = buf_mode ? {1'b0, raw_hit[LAST-1:0]} : raw_hit;
  assign buf_take = buf_mode && raw_hit[LAST];

  can_flt_prio u_prio (
    .req (ranked),
    .any (ranked_any),
    .num (ranked_num)
  );

  logic              nxt_hit;
  logic [OBJ_IW-1:0] nxt_obj;
  logic [DLC_W-1:0]  nxt_len;

  always_comb begin
    nxt_hit = ranked_any || buf_take;
    if (ranked_any)    nxt_obj = ranked_num;
    else if (buf_take) nxt_obj = OBJ_IW'(OBJ_N);
    else               nxt_obj = '0;
    nxt_len = (hdr_dlc > DLC_W'(MAX_LEN)) ? DLC_W'(MAX_LEN) : hdr_dlc;
  end

  logic take;
  assign hdr_ready = !res_valid || res_ready;
  assign take      = hdr_valid && hdr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_obj   <= '0;
      res_len   <= '0;
    end else if (take) begin
      res_valid <= 1'b1;
      res_hit   <= nxt_hit;
      res_obj   <= nxt_obj;
      res_len   <= nxt_len;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/can_flt_chk.sv
module can_flt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hdr_valid,
  input logic       hdr_ready,
  input logic       res_valid,
  input logic       res_ready,
  input logic       res_hit,
  input logic [3:0] res_obj,
  input logic [3:0] res_len
);
  // R9
  result_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && hdr_ready |=> res_valid);

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_hit) && $stable(res_obj) && $stable(res_len));

  // R8
  len_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_len <= 4'd8);

  // R9
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_hit |-> res_obj == 4'd0);

  // R9
  hit_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_hit |-> res_obj != 4'd0);
endmodule

bind can_accept_filter can_flt_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .hdr_valid (hdr_valid),
  .hdr_ready (hdr_ready),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_hit   (res_hit),
  .res_obj   (res_obj),
  .res_len   (res_len)
);

// File: tb/can_accept_filter_tb.sv
module can_accept_filter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        hdr_valid = 1'b0;
  logic        hdr_ready;
  logic [28:0] hdr_id = '0;
  logic        hdr_ext = 1'b0;
  logic [3:0]  hdr_dlc = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic        res_hit;
  logic [3:0]  res_obj;
  logic [3:0]  res_len;

  always #4 clk = ~clk;

  can_accept_filter u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_id(hdr_id), .hdr_ext(hdr_ext),
    .hdr_dlc(hdr_dlc), .res_valid(res_valid), .res_ready(res_ready), .res_hit(res_hit),
    .res_obj(res_obj), .res_len(res_len)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [31:0] m_tbl [15];
  logic [28:0] m_fmask, m_bmask;
  logic        m_mode;

  function automatic logic [31:0] obj_w(bit en, bit rx, bit ext, logic [28:0] id);
    return {en, rx, ext, id};
  endfunction

  function automatic logic [28:0] sid(logic [10:0] v);
    return {v, 18'h0};
  endfunction

  function automatic bit m_match(int s, logic [28:0] mask, logic [28:0] id, bit ext);
    logic [31:0] e = m_tbl[s];
    if (!(e[31] && e[30] && (e[29] == ext))) return 0;
    if (ext) return ((id ^ e[28:0]) & mask) == 0;
    return ((id[28:18] ^ e[28:18]) & mask[28:18]) == 0;
  endfunction

  function automatic logic [9:0] expect_res(logic [28:0] id, bit ext, logic [3:0] dlc);
    logic [3:0] len = (dlc > 4'd8) ? 4'd8 : dlc;
    for (int s = 0; s < 15; s++) begin
      if (s == 14 && m_mode) continue;
      if (m_match(s, m_fmask, id, ext)) return {1'b1, 1'b1, 4'(s + 1), len};
    end
    if (m_mode && m_match(14, m_bmask, id, ext)) return {1'b1, 1'b1, 4'd15, len};
    return {1'b1, 1'b0, 4'd0, len};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    if (a < 5'd15) m_tbl[a] = d;
    else if (a == 5'd16) m_fmask = d[28:0];
    else if (a == 5'd17) m_bmask = d[28:0];
    else if (a == 5'd18) m_mode = d[0];
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic xact(string req, logic [28:0] id, bit ext, logic [3:0] dlc);
    @(negedge clk);
    hdr_valid = 1'b1; hdr_id = id; hdr_ext = ext; hdr_dlc = dlc;
    @(negedge clk);
    hdr_valid = 1'b0;
    check(req, {22'd0, res_valid, res_hit, res_obj, res_len}, {22'd0, expect_res(id, ext, dlc)});
  endtask

  task automatic std_sweep(string req);
    for (int v = 0; v < 2048; v++)
      xact(req, {11'(v), 18'($urandom)}, 1'b0, 4'($urandom_range(0, 8)));
  endtask

  localparam logic [28:0] EXT_A = 29'h0ABC_DE12;

  initial begin : main
    for (int s = 0; s < 15; s++) m_tbl[s] = '0;
    m_fmask = '1; m_bmask = '1; m_mode = 1'b0;
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12", {30'd0, res_valid, hdr_ready}, 32'd1);
    rst_n = 1'b1;
    xact("R12", sid(11'h123), 1'b0, 4'd3);
    xact("R12", EXT_A, 1'b1, 4'd3);

    // shared mask, buffer off
    cfg(5'd0,  obj_w(1, 1, 0, sid(11'h123)));
    cfg(5'd1,  obj_w(1, 1, 1, EXT_A));
    cfg(5'd2,  obj_w(1, 0, 0, sid(11'h456)));       // transmit: never matches (R3)
    cfg(5'd3,  obj_w(0, 1, 0, sid(11'h789)));       // disabled (R3)
    cfg(5'd4,  obj_w(1, 1, 0, sid(11'h123)));       // duplicate of 1 (R5)
    cfg(5'd5,  obj_w(1, 1, 1, sid(11'h456)));       // extended twin of a base id (R3)
    cfg(5'd14, obj_w(1, 1, 0, sid(11'h7FF)));
    std_sweep("R2_R3_R5");
    for (int b = 0; b < 29; b++) xact("R1", EXT_A ^ (29'd1 << b), 1'b1, 4'd8);
    xact("R1", EXT_A, 1'b1, 4'd2);
    xact("R3", sid(11'h456), 1'b1, 4'd1);
    for (int k = 0; k < 64; k++) xact("R1", 29'($urandom), 1'b1, 4'($urandom));

    // don't-care bits in shared mask, object 15 uses it (R4, R7)
    cfg(5'd16, {3'b0, 11'h7F0, 18'h3FFFF});
    std_sweep("R4_R7");
    cfg(5'd16, {3'b0, 29'h1FFF_FF00});
    for (int k = 0; k < 64; k++) xact("R4", {EXT_A[28:8], 8'($urandom)}, 1'b1, 4'd4);
    xact("R4", EXT_A ^ 29'h100, 1'b1, 4'd4);

    // buffer mode: catch-all then partial mask (R6)
    cfg(5'd16, '1);
    cfg(5'd17, '0);
    cfg(5'd18, 32'd1);
    std_sweep("R6");
    xact("R6", EXT_A ^ 29'h1, 1'b1, 4'd5);
    cfg(5'd17, {3'b0, 11'h700, 18'h0});
    std_sweep("R6");

    // single-object rewrite (R11)
    cfg(5'd0, obj_w(1, 1, 0, sid(11'h055)));
    std_sweep("R11");
    xact("R11", EXT_A, 1'b1, 4'd7);

    // length clamp over all codes (R8)
    for (int d = 0; d < 16; d++) begin
      xact("R8", sid(11'h123), 1'b0, 4'(d));
      xact("R8", 29'h1555_5555, 1'b1, 4'(d));
    end

    // back-pressure (R10)
    @(negedge clk);
    res_ready = 1'b0;
    hdr_valid = 1'b1; hdr_id = sid(11'h123); hdr_ext = 1'b0; hdr_dlc = 4'd12;
    @(negedge clk);
    hdr_id = EXT_A; hdr_ext = 1'b1; hdr_dlc = 4'd3;
    check("R10", {22'd0, res_valid, res_hit, res_obj, res_len}, {22'd0, 1'b1, 1'b1, 4'd5, 4'd8});
    repeat (3) begin
      @(negedge clk);
      check("R10", {21'd0, hdr_ready, res_valid, res_hit, res_obj, res_len},
            {21'd0, 1'b0, 1'b1, 1'b1, 4'd5, 4'd8});
    end
    res_ready = 1'b1;
    @(negedge clk);
    hdr_valid = 1'b0;
    check("R10", {22'd0, res_valid, res_hit, res_obj, res_len}, {22'd0, expect_res(EXT_A, 1'b1, 4'd3)});
    @(negedge clk);
    check("R10", {30'd0, res_valid, hdr_ready}, 32'd1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule